// File: doc/BRIEF.md
# FIFO Level DMA Request Generator

This block is a byte-wide synchronous FIFO with an 8-bit control register. The register decides when the block raises a DMA request line, based on how many bytes the FIFO holds. A DMA engine that refills a draining FIFO picks an "at or below" threshold. An engine that empties a filling FIFO picks an "at or above" threshold. The threshold points are one quarter, one half and three quarters of capacity, and a further code requests whenever any byte is stored.

The control register holds an enable bit and a 3-bit condition code. The request output is a flop. At each clock it is re-evaluated from the current occupancy and the current register contents, so it follows any change one cycle later. The FIFO is show-ahead: `pop_data_o` presents the oldest byte while the FIFO is not empty.

Top module: `fifo_dma_req`

## Requirements
- R1: After reset, `reg_rdata_o` reads 0x00, `dma_req_o` is 0 and `empty_o` is 1.
- R2: Control register layout: bit 7 is the enable, bits 2:0 are the condition code, and bits 6:3 always read 0 whatever was written to them (writing 0xFF reads back 0x87).
- R3: While the enable bit is 0, `dma_req_o` stays 0 for every condition code and occupancy.
- R4: Condition code 0 (binary 000) never raises `dma_req_o`.
- R5: Codes 1, 2 and 3 raise the request when the stored byte count is at or below DEPTH/4, DEPTH/2 and 3*DEPTH/4 respectively.
- R6: Code 4 raises the request whenever at least one byte is stored.
- R7: Codes 5, 6 and 7 raise the request when the stored byte count is at or above DEPTH/4, DEPTH/2 and 3*DEPTH/4 respectively.
- R8: `dma_req_o` reflects the occupancy and register contents as they stood after the previous clock edge. A push, pop or register write therefore changes the request one cycle after the edge that performs it.
- R9: Bytes leave in the order they entered. A push and a pop in the same cycle leave the occupancy unchanged, and this includes a full FIFO.
- R10: A push on a full FIFO without a pop, and a pop on an empty FIFO, are ignored and leave the occupancy unchanged.
- R11: `full_o` is 1 exactly when DEPTH bytes are stored, and `empty_o` is 1 exactly when none are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write a byte into the FIFO |
| push_data_i | input | 8 | Byte to write |
| pop_i | input | 1 | Remove the oldest byte |
| pop_data_o | output | 8 | Oldest stored byte (show-ahead) |
| full_o | output | 1 | FIFO holds DEPTH bytes |
| empty_o | output | 1 | FIFO holds no bytes |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| dma_req_o | output | 1 | Registered DMA request |

## Verification
The bench builds the block with DEPTH = 8, so the thresholds fall at 2, 4 and 6 bytes. At that size every condition code can be swept through all nine occupancy levels from empty to full within a short run. The small depth also puts the full and empty boundaries, the push into a full FIFO and the pop from an empty one within a few cycles of each other. Every threshold is an exact integer, so each "at or below" and "at or above" comparison is tested on both sides of its boundary.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  typedef enum logic [2:0] {
    COND_OFF     = 3'd0,
    COND_LE_Q1   = 3'd1,
    COND_LE_HALF = 3'd2,
    COND_LE_Q3   = 3'd3,
    COND_ANY     = 3'd4,
    COND_GE_Q1   = 3'd5,
    COND_GE_HALF = 3'd6,
    COND_GE_Q3   = 3'd7
  } cond_e;

  typedef struct packed {
    logic  en;
    cond_e cond;
  } cfg_t;

  localparam int unsigned EN_BIT = 7;
endpackage

// File: rtl/fdr_fifo.sv
module fdr_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (!full_o || pop_ok);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign pop_data_o = mem_q[rd_ptr_q];
  assign count_o    = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R10
  AST_FULL_PUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(count_q)); // R10
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> $stable(count_q)); // R10
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o) |=> $stable(count_q)); // R9
endmodule

// File: rtl/fdr_ctrl_reg.sv
module fdr_ctrl_reg
  import fdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{en: 1'b0, cond: COND_OFF};
    end else if (we_i) begin
      cfg_q.en   <= wdata_i[EN_BIT];
      cfg_q.cond <= cond_e'(wdata_i[2:0]);
    end
  end

  // reserved bits 6:3 are not stored
  assign rdata_o = {cfg_q.en, 4'b0000, cfg_q.cond};
  assign cfg_o   = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q)); // R2
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_o.en == $past(wdata_i[EN_BIT]))); // R2
endmodule

// File: rtl/fdr_req_eval.sv
module fdr_req_eval
  import fdr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned Q1   = DEPTH / 4,
  localparam int unsigned HALF = DEPTH / 2,
  localparam int unsigned Q3   = 3 * DEPTH / 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cfg_t          cfg_i,
  input  logic [CW-1:0] count_i,
  output logic          req_o
);
  logic hit;
  logic req_q;

  always_comb begin
    unique case (cfg_i.cond)
      COND_OFF:     hit = 1'b0;
      COND_LE_Q1:   hit = count_i <= CW'(Q1);
      COND_LE_HALF: hit = count_i <= CW'(HALF);
      COND_LE_Q3:   hit = count_i <= CW'(Q3);
      COND_ANY:     hit = count_i != '0;
      COND_GE_Q1:   hit = count_i >= CW'(Q1);
      COND_GE_HALF: hit = count_i >= CW'(HALF);
      COND_GE_Q3:   hit = count_i >= CW'(Q3);
      default:      hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= cfg_i.en && hit;
  end

  assign req_o = req_q;

  AST_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> !req_o); // R3
  AST_CODE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.cond == COND_OFF) |=> !req_o); // R4
  AST_ANY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.cond == COND_ANY && count_i == '0) |=> !req_o); // R6
  AST_ANY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && cfg_i.cond == COND_ANY && count_i != '0) |=> req_o); // R6
endmodule

// File: rtl/fifo_dma_req.sv
module fifo_dma_req
  import fdr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] push_data_i,
  input  logic       pop_i,
  output logic [7:0] pop_data_o,
  output logic       full_o,
  output logic       empty_o,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       dma_req_o
);
  cfg_t          cfg;
  logic [CW-1:0] count;

  initial begin
    assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("DEPTH must be a power of two, at least 4");
  end

  fdr_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i, .rst_ni, .push_i, .push_data_i, .pop_i, .pop_data_o,
    .full_o, .empty_o, .count_o(count)
  );

  fdr_ctrl_reg u_reg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .cfg_o(cfg)
  );

  fdr_req_eval #(.DEPTH(DEPTH)) u_eval (
    .clk_i, .rst_ni, .cfg_i(cfg), .count_i(count), .req_o(dma_req_o)
  );
endmodule

// File: tb/fifo_dma_req_tb.sv
module fifo_dma_req_tb;
  localparam int D = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, reg_we_i = 1'b0;
  logic [7:0] push_data_i = '0, reg_wdata_i = '0;
  logic [7:0] pop_data_o, reg_rdata_o;
  logic       full_o, empty_o, dma_req_o;

  int n_chk = 0, n_fail = 0, mcount = 0;
  logic [7:0] sbq[$];
  logic [7:0] dcnt = 8'h10;

  always #5 clk_i = ~clk_i;

  fifo_dma_req #(.DEPTH(D)) u_dut (.*);

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit exp_req(input bit en, input int code, input int lvl);
    case (code)
      1: return en && lvl <= D/4;
      2: return en && lvl <= D/2;
      3: return en && lvl <= 3*D/4;
      4: return en && lvl >= 1;
      5: return en && lvl >= D/4;
      6: return en && lvl >= D/2;
      7: return en && lvl >= 3*D/4;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag(input int code);
    if (code == 0) return "R4";
    if (code <= 3) return "R5";
    if (code == 4) return "R6";
    return "R7";
  endfunction

  // monitor: compare popped bytes against the scoreboard (R9)
  always @(posedge clk_i) begin
    if (rst_ni && pop_i && !empty_o) begin
      if (sbq.size() == 0) chk(1'b0, "R9 unexpected pop", pop_data_o, 0);
      else begin
        automatic logic [7:0] e = sbq.pop_front();
        chk(pop_data_o == e, "R9 order", pop_data_o, e);
      end
    end
  end

  task automatic step(input bit p, input bit q);
    bit pq, pa;
    pq = q && mcount > 0;
    pa = p && (mcount < D || pq);
    push_i = p; pop_i = q; push_data_i = dcnt;
    if (pa) sbq.push_back(dcnt);
    dcnt++;
    mcount = mcount + int'(pa) - int'(pq);
    @(posedge clk_i); @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we_i = 1'b1; reg_wdata_i = v;
    @(posedge clk_i); @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic drain();
    while (mcount > 0) step(1'b0, 1'b1);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(reg_rdata_o == 8'h00, "R1 rdata", reg_rdata_o, 0);
    chk(dma_req_o == 1'b0, "R1 req", dma_req_o, 0);
    chk(empty_o == 1'b1, "R1 empty", empty_o, 1);

    wr(8'hFF);
    chk(reg_rdata_o == 8'h87, "R2 reserved", reg_rdata_o, 8'h87);
    wr(8'h78);
    chk(reg_rdata_o == 8'h00, "R2 reserved only", reg_rdata_o, 0);

    // full sweep: every code, every level (R4 R5 R6 R7 R11)
    for (int code = 0; code < 8; code++) begin
      drain();
      wr(8'h80 | 8'(code));
      for (int lvl = 0; lvl <= D; lvl++) begin
        step(1'b0, 1'b0);
        chk(dma_req_o == exp_req(1'b1, code, lvl), tag(code), dma_req_o, exp_req(1'b1, code, lvl));
        chk(full_o == (lvl == D), "R11 full", full_o, lvl == D);
        chk(empty_o == (lvl == 0), "R11 empty", empty_o, lvl == 0);
        if (lvl < D) step(1'b1, 1'b0);
      end
    end

    // R10 push on full ignored (code 7 still active, level D)
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk(full_o == 1'b1, "R10 full push", full_o, 1);
    wr(8'h81); // <= D/4 must stay low at full
    step(1'b0, 1'b0);
    chk(dma_req_o == 1'b0, "R10 level kept", dma_req_o, 0);
    // R9 push+pop on full
    step(1'b1, 1'b1);
    chk(full_o == 1'b1, "R9 both at full", full_o, 1);

    // R3 enable clear
    drain();
    repeat (D/2) step(1'b1, 1'b0);
    wr(8'h86);
    step(1'b0, 1'b0);
    chk(dma_req_o == 1'b1, "R7 half", dma_req_o, 1);
    // R9 push+pop at D/2 keeps request
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    chk(dma_req_o == 1'b1, "R9 both mid", dma_req_o, 1);
    wr(8'h06);
    chk(dma_req_o == 1'b1, "R8 write latency", dma_req_o, 1);
    step(1'b0, 1'b0);
    chk(dma_req_o == 1'b0, "R3 disabled", dma_req_o, 0);
    for (int i = 0; i < D/2; i++) begin
      step(1'b1, 1'b0);
      chk(dma_req_o == 1'b0, "R3 disabled fill", dma_req_o, 0);
    end

    // R8 push latency with code 4
    drain();
    wr(8'h84);
    step(1'b0, 1'b0);
    chk(dma_req_o == 1'b0, "R6 empty", dma_req_o, 0);
    step(1'b1, 1'b0);
    chk(dma_req_o == 1'b0, "R8 push latency", dma_req_o, 0);
    step(1'b0, 1'b0);
    chk(dma_req_o == 1'b1, "R8 push follows", dma_req_o, 1);

    // R10 pop on empty ignored
    drain();
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk(empty_o == 1'b1, "R10 empty pop", empty_o, 1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk(dma_req_o == 1'b1 && !empty_o, "R10 count intact", dma_req_o, 1);
    drain();
    chk(sbq.size() == 0, "R9 scoreboard drained", sbq.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule